// File: doc/BRIEF.md
# Packed SIMD Media ALU

This block is a 64-bit packed-integer arithmetic unit for media kernels. A lane-size select splits each operand into eight 8-bit lanes, four 16-bit lanes or two 32-bit lanes. The selected operation then runs on every lane at the same time, with no interaction between lanes.

The opcode picks one of the following:
- add or subtract, each in three variants: wrapping, signed-saturating and unsigned-saturating;
- three shifts with a single count;
- four bitwise logic functions;
- two compares that produce full-lane masks;
- a signed-saturating pack that narrows two operands into one word.

The datapath is combinational. A parameter adds an output register so the unit can sit in a pipeline stage.

Top module: `simd_media_alu`

## Requirements
- R1: `size_i` sets the lane width: 0 gives 8-bit lanes, 1 gives 16-bit lanes and 2 gives 32-bit lanes. Value 3 is reserved. With value 3, every lane-wise opcode (0 to 8, 13, 14) returns zero.
- R2: Opcode 0 (add) and opcode 3 (subtract, A minus B) wrap modulo the lane width. No carry or borrow crosses into a neighbouring lane.
- R3: Opcodes 1 (add) and 4 (subtract) saturate signed. On overflow the lane is clamped to the most positive or most negative lane value.
- R4: Opcodes 2 (add) and 5 (subtract) saturate unsigned. An add overflow gives all ones and a subtract underflow gives zero.
- R5: Opcodes 6 (shift left logical), 7 (shift right logical) and 8 (shift right arithmetic) shift every lane of A by the unsigned count in B[7:0]. A count at or above the lane width gives zero for the logical shifts and a full sign fill for the arithmetic shift.
- R6: Opcodes 9 (A AND B), 10 ((NOT A) AND B), 11 (OR) and 12 (XOR) act bitwise on the full word, whatever `size_i` holds.
- R7: Opcode 13 (equal) and opcode 14 (signed A greater than B) set each result lane to all ones when the test is true and to all zeros when it is false.
- R8: Opcode 15 (pack) narrows signed lanes with saturation. With `size_i`=1, 16-bit lanes narrow to 8 bits. With `size_i`=2, 32-bit lanes narrow to 16 bits. The narrowed lanes of A fill the low 32 bits of the result in lane order, and those of B fill the high 32 bits. With `size_i`=0 or 3, pack returns zero.
- R9: With OUT_REG=1, `res_o` resets to zero. It shows the result for the inputs present at a rising clock edge from that edge on, and holds it until the next edge. With OUT_REG=0, `res_o` is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| a_i | input | DATA_W | Operand A |
| b_i | input | DATA_W | Operand B; B[7:0] is the shift count |
| op_i | input | 4 | Opcode |
| size_i | input | 2 | Lane-size select |
| res_o | output | DATA_W | Result |

## Verification
The clocked assertions assume that `op_i`, `size_i` and both operands are stable and known at every rising edge once reset is released. Several of them also assume that the lane size is a legal one whenever the expected result depends on it. The stimulus changes inputs only on falling edges and never drives X after reset. Sweeps include the reserved size and compare it against a zero expectation, and the size-dependent assertions exclude that value in their antecedents. Operand corners (zero, all ones, lane maxima and minima, and mixed signs) are crossed exhaustively for every opcode and size. Shift counts are swept from 0 to 63.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,  OP_ADDS = 4'd1,  OP_ADDU = 4'd2,
    OP_SUB  = 4'd3,  OP_SUBS = 4'd4,  OP_SUBU = 4'd5,
    OP_SLL  = 4'd6,  OP_SRL  = 4'd7,  OP_SRA  = 4'd8,
    OP_AND  = 4'd9,  OP_ANDN = 4'd10, OP_OR   = 4'd11,
    OP_XOR  = 4'd12, OP_CEQ  = 4'd13, OP_CGT  = 4'd14,
    OP_PACK = 4'd15
  } simd_op_e;

  localparam int unsigned CNT_W     = 8;
  localparam int unsigned NUM_SIZES = 3;
endpackage

// File: rtl/simd_lane_ops.sv
module simd_lane_ops
  import simd_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned LANE_W = 8
) (
  input  simd_op_e          op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o
);
  localparam int unsigned NUM_LANES = DATA_W / LANE_W;
  localparam int unsigned MSB       = LANE_W - 1;
  localparam logic [LANE_W-1:0] SMAX = {1'b0, {(LANE_W-1){1'b1}}};
  localparam logic [LANE_W-1:0] SMIN = {1'b1, {(LANE_W-1){1'b0}}};

  logic [CNT_W-1:0] cnt;
  assign cnt = b_i[CNT_W-1:0];

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    logic [LANE_W-1:0] la, lb, r;
    logic [LANE_W:0]   sum, dif;
    logic              ovf_add, ovf_sub;

    assign la  = a_i[g*LANE_W +: LANE_W];
    assign lb  = b_i[g*LANE_W +: LANE_W];
    assign sum = {1'b0, la} + {1'b0, lb};
    assign dif = {1'b0, la} - {1'b0, lb};
    // signed overflow: result sign disagrees with what the operands allow
    assign ovf_add = (la[MSB] == lb[MSB]) && (sum[MSB] != la[MSB]);
    assign ovf_sub = (la[MSB] != lb[MSB]) && (dif[MSB] != la[MSB]);

    always_comb begin
      case (op_i)
        OP_ADD:  r = sum[LANE_W-1:0];
        OP_ADDS: r = ovf_add ? (la[MSB] ? SMIN : SMAX) : sum[LANE_W-1:0];
        OP_ADDU: r = sum[LANE_W] ? '1 : sum[LANE_W-1:0];
        OP_SUB:  r = dif[LANE_W-1:0];
        OP_SUBS: r = ovf_sub ? (la[MSB] ? SMIN : SMAX) : dif[LANE_W-1:0];
        OP_SUBU: r = dif[LANE_W] ? '0 : dif[LANE_W-1:0];
        OP_SLL:  r = la << cnt;
        OP_SRL:  r = la >> cnt;
        OP_SRA:  r = $signed(la) >>> cnt;
        OP_CEQ:  r = {LANE_W{la == lb}};
        OP_CGT:  r = {LANE_W{$signed(la) > $signed(lb)}};
        default: r = '0;
      endcase
    end

    assign res_o[g*LANE_W +: LANE_W] = r;
  end
endmodule

// File: rtl/simd_pack.sv
module simd_pack #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned SRC_W  = 16
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o
);
  localparam int unsigned DST_W  = SRC_W / 2;
  localparam int unsigned NUM_SRC = DATA_W / SRC_W;
  localparam int unsigned HALF   = DATA_W / 2;

  function automatic logic [DST_W-1:0] narrow(input logic [SRC_W-1:0] v);
    logic [SRC_W-DST_W:0] top;
    top = v[SRC_W-1:DST_W-1];
    if (&top || ~|top) return v[DST_W-1:0];
    return v[SRC_W-1] ? {1'b1, {(DST_W-1){1'b0}}} : {1'b0, {(DST_W-1){1'b1}}};
  endfunction

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign res_o[i*DST_W +: DST_W]        = narrow(a_i[i*SRC_W +: SRC_W]);
    assign res_o[HALF + i*DST_W +: DST_W] = narrow(b_i[i*SRC_W +: SRC_W]);
  end
endmodule

// File: rtl/simd_media_alu.sv
module simd_media_alu
  import simd_alu_pkg::*;
#(
  parameter int unsigned DATA_W  = 64,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [3:0]        op_i,
  input  logic [1:0]        size_i,
  output logic [DATA_W-1:0] res_o
);
  simd_op_e          op;
  logic [DATA_W-1:0] lane_res [NUM_SIZES];
  logic [DATA_W-1:0] pack_res [NUM_SIZES];
  logic [DATA_W-1:0] res_c;

  assign op = simd_op_e'(op_i);

  for (genvar gs = 0; gs < NUM_SIZES; gs++) begin : g_size
    simd_lane_ops #(.DATA_W(DATA_W), .LANE_W(8 << gs)) u_lanes (
      .op_i (op),
      .a_i  (a_i),
      .b_i  (b_i),
      .res_o(lane_res[gs])
    );
    if (gs == 0) begin : g_nopack
      assign pack_res[gs] = '0;  // nothing narrower than a byte
    end else begin : g_pack
      simd_pack #(.DATA_W(DATA_W), .SRC_W(8 << gs)) u_pack (
        .a_i  (a_i),
        .b_i  (b_i),
        .res_o(pack_res[gs])
      );
    end
  end

  always_comb begin
    case (op)
      OP_AND:  res_c = a_i & b_i;
      OP_ANDN: res_c = ~a_i & b_i;
      OP_OR:   res_c = a_i | b_i;
      OP_XOR:  res_c = a_i ^ b_i;
      OP_PACK: res_c = (size_i == 2'd3) ? '0 : pack_res[size_i];
      default: res_c = (size_i == 2'd3) ? '0 : lane_res[size_i];
    endcase
  end

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) res_o <= '0;
      else         res_o <= res_c;
    end

    AST_ADD_ZERO_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op == OP_ADD && b_i == '0 && size_i != 2'd3) |=> res_o == $past(a_i)); // R2
    AST_SUBU_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op == OP_SUBU && a_i == b_i) |=> res_o == '0); // R4
    AST_ADDU_CEIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op == OP_ADDU && b_i == '1 && size_i != 2'd3) |=> res_o == '1); // R4
    AST_SHIFT_NONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((op == OP_SLL || op == OP_SRL || op == OP_SRA) && b_i[CNT_W-1:0] == '0
       && size_i != 2'd3) |=> res_o == $past(a_i)); // R5
    AST_XOR_SELF: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op == OP_XOR && a_i == b_i) |=> res_o == '0); // R6
    AST_CEQ_SELF: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op == OP_CEQ && a_i == b_i && size_i != 2'd3) |=> res_o == '1); // R7
    AST_CGT_SELF: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op == OP_CGT && a_i == b_i) |=> res_o == '0); // R7
    AST_RSV_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (size_i == 2'd3 && op != OP_AND && op != OP_ANDN && op != OP_OR
       && op != OP_XOR) |=> res_o == '0); // R1
  end else begin : g_comb
    assign res_o = res_c;
  end
endmodule

// File: tb/simd_media_alu_tb.sv
`timescale 1ns/1ps
module simd_media_alu_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] a = '0, b = '0;
  logic [3:0]  op = '0;
  logic [1:0]  sz = '0;
  logic [63:0] res;
  int          checks = 0, fails = 0;
  logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

  always #4 clk = ~clk;

  simd_media_alu #(.DATA_W(64), .OUT_REG(1'b1)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a), .b_i(b),
    .op_i(op), .size_i(sz), .res_o(res)
  );

  function automatic logic [63:0] corner(int j);
    case (j)
      0: return 64'h0;
      1: return '1;
      2: return 64'h7F7F_7F7F_7F7F_7F7F;
      3: return 64'h8080_8080_8080_8080;
      4: return 64'h7FFF_FFFF_8000_0000;
      5: return 64'h0001_00FF_FFFF_0010;
      6: return 64'h8000_7FFF_0001_FF05;
      default: return 64'h0123_4567_89AB_CDEF;
    endcase
  endfunction

  function automatic string req_of(int o, int s);
    if (s == 3 && (o < 9 || o == 13 || o == 14)) return "R1";
    case (o)
      0, 3: return "R2";
      1, 4: return "R3";
      2, 5: return "R4";
      6, 7, 8: return "R5";
      9, 10, 11, 12: return "R6";
      13, 14: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic longint clamp(longint v, longint lo, longint hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  function automatic longint sext(longint u, int w);
    return (u >= (longint'(1) << (w - 1))) ? u - (longint'(1) << w) : u;
  endfunction

  function automatic logic [63:0] model(int o, int s, logic [63:0] x, logic [63:0] y);
    logic [63:0] r = '0;
    int w, cnt;
    longint m, ua, ub, sa, sb, v;
    case (o)
      9:  return x & y;
      10: return ~x & y;
      11: return x | y;
      12: return x ^ y;
      default: ;
    endcase
    if (s == 3) return '0;
    w = 8 << s;
    m = (longint'(1) << w) - 1;
    if (o == 15) begin // R8 pack
      int d;
      longint dm;
      if (s == 0) return '0;
      d = w / 2;
      dm = (longint'(1) << d) - 1;
      for (int i = 0; i < 64 / w; i++) begin
        v = clamp(sext(longint'((x >> (i*w)) & 64'(m)), w),
                  -(longint'(1) << (d-1)), (longint'(1) << (d-1)) - 1);
        r |= (64'(v & dm)) << (i*d);
        v = clamp(sext(longint'((y >> (i*w)) & 64'(m)), w),
                  -(longint'(1) << (d-1)), (longint'(1) << (d-1)) - 1);
        r |= (64'(v & dm)) << (32 + i*d);
      end
      return r;
    end
    cnt = int'(y[7:0]);
    for (int i = 0; i < 64 / w; i++) begin
      ua = longint'((x >> (i*w)) & 64'(m));
      ub = longint'((y >> (i*w)) & 64'(m));
      sa = sext(ua, w);
      sb = sext(ub, w);
      case (o)
        0: v = ua + ub;
        1: v = clamp(sa + sb, -(longint'(1) << (w-1)), (longint'(1) << (w-1)) - 1);
        2: v = clamp(ua + ub, 0, m);
        3: v = ua - ub;
        4: v = clamp(sa - sb, -(longint'(1) << (w-1)), (longint'(1) << (w-1)) - 1);
        5: v = clamp(ua - ub, 0, m);
        6: v = (cnt >= w) ? 0 : (ua << cnt);
        7: v = (cnt >= w) ? 0 : (ua >> cnt);
        8: v = sa >>> ((cnt >= w) ? w - 1 : cnt);
        13: v = (ua == ub) ? m : 0;
        default: v = (sa > sb) ? m : 0;
      endcase
      r |= (64'(v & m)) << (i*w);
    end
    return r;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp, int o, int s);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s op=%0d size=%0d actual=%h expected=%h", req, o, s, act, exp);
    end
  endtask

  function automatic logic [63:0] next_rng(logic [63:0] v);
    logic [63:0] t = v;
    t ^= t << 13;
    t ^= t >> 7;
    t ^= t << 17;
    return t;
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    logic [63:0] exp, prev;
    repeat (3) @(negedge clk);
    check("R9", res, 64'h0, 0, 0);  // reset value
    rst_n = 1'b1;
    prev = '0;
    for (int o = 0; o < 16; o++) begin
      for (int s = 0; s < 4; s++) begin
        for (int k = 0; k < 128; k++) begin
          logic [63:0] x, y;
          if (k < 64) begin
            x = corner(k % 8);
            y = corner(k / 8);
          end else begin
            rng = next_rng(rng);
            x = rng;
            rng = next_rng(rng);
            y = rng;
            if (o >= 6 && o <= 8) y[7:0] = 8'(k - 64);
          end
          exp = model(o, s, x, y);
          a = x; b = y; op = 4'(o); sz = 2'(s);
          #1;
          check("R9", res, prev, o, s);  // registered output holds until edge
          @(negedge clk);
          check(req_of(o, s), res, exp, o, s);
          prev = exp;
        end
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule